// File: doc/BRIEF.md
# Segmented TLB Address Translator

This block turns a 32-bit virtual address into a physical address for a processor that runs in either user or kernel mode. The top three address bits pick a segment. Two kernel windows skip translation and map straight onto the lowest 512 MB of physical memory: one of them is cacheable and the other is not. The user segment (bit 31 clear) and the upper kernel segment (top bits 11) are translated through a 64-entry fully associative TLB. Every TLB entry is tagged with a 6-bit process number. The lookup path is combinational. Each cycle it reports a result kind, a physical address and a cacheable flag.

Software maintains the TLB through three registers: a high entry word (page number and current process number), a low entry word (frame number and flags) and an index register. Four single-cycle operations act on them: probe, indexed read, indexed write and random write. A free-running victim counter steps down on every clock and never names the eight lowest entries, so those entries stay available for pinned mappings.

The segment decode states are SEG_USEG (bit 31 = 0, mapped), SEG_KCACHED (top bits 100), SEG_KUNCACHED (top bits 101) and SEG_KMAPPED (top bits 11). The result kinds are XL_HIT, XL_ADDR_ERR, XL_UMISS, XL_KMISS and XL_MOD. The result is chosen on each cycle as follows:
- An address error is taken first, for a user-mode access with bit 31 set.
- An unmapped segment then goes directly to XL_HIT.
- A mapped segment goes to a miss if no entry matches, or to XL_KMISS if the matching entry is not valid.
- A write to a matching entry whose writable flag is clear goes to XL_MOD.
- Any other mapped access goes to XL_HIT.

The maintenance operations are OP_PROBE, OP_READ, OP_WR_IDX and OP_WR_RND.

Top module: `seg_tlb_xlate`

## Requirements
- R1: After reset, every TLB entry is all zero, the high and low entry words and the index read 0, and the random counter reads 63.
- R2: In user mode, an address with bit 31 set gives kind 1 (address error), and pa 0 with cacheable 0.
- R3: In kernel mode, an address with top bits 100 gives kind 0, pa = {3'b000, va[28:0]} and cacheable 1, without using the TLB.
- R4: In kernel mode, an address with top bits 101 gives kind 0 and pa = {3'b000, va[28:0]} with cacheable 0.
- R5: A mapped address hits when an entry's page number equals va[31:12] and either its process number equals high-word bits [11:6] or its global flag (low-word bit 8) is set. A hit gives kind 0, pa = {frame, va[11:0]} and cacheable equal to the inverse of the no-cache flag (low-word bit 11).
- R6: A mapped address with no matching entry gives kind 2 when va[31] is 0 and kind 3 when it is 1. For every kind other than 0, pa and cacheable are 0.
- R7: A matching entry whose valid flag (low-word bit 9) is clear gives kind 3, in both mapped segments.
- R8: A write (is_write_i = 1) that matches a valid entry whose writable flag (low-word bit 10) is clear gives kind 4. A read of the same entry hits.
- R9: Probe (op 0) searches the TLB using the high word's page number and process number. On a match it loads the matching index into the index register with flag bit 6 clear. With no match it loads 7'h40.
- R10: Indexed read (op 1) copies the entry at index bits [5:0] into the high and low words.
- R11: Indexed write (op 2) stores the high and low words into the entry at index bits [5:0]. Random write (op 3) stores them into the entry named by the random counter's value in that cycle.
- R12: The random counter decreases by one on every clock, wraps from 8 back to 63, and never reads below 8.
- R13: A register write stores the data as follows, based on sel:
  - sel 0 writes the high word, with bits [5:0] reading 0.
  - sel 1 writes the low word, with bits [7:0] reading 0.
  - sel 2 writes the index: bit 6 comes from data bit 31 and bits [5:0] from data bits [5:0].

  Sel 3 has no effect, and a register write in a cycle with op_en_i set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| va_i | input | 32 | Virtual address to translate |
| user_mode_i | input | 1 | 1 = user mode access |
| is_write_i | input | 1 | 1 = store access |
| pa_o | output | 32 | Physical address (0 on any fault) |
| kind_o | output | 3 | 0 hit, 1 address error, 2 user-segment miss, 3 general miss, 4 modify fault |
| cacheable_o | output | 1 | Access may use the cache |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | 0 high word, 1 low word, 2 index, 3 none |
| reg_wdata_i | input | 32 | Register write data |
| op_en_i | input | 1 | Maintenance operation strobe |
| op_i | input | 2 | 0 probe, 1 indexed read, 2 indexed write, 3 random write |
| entry_hi_o | output | 32 | High entry word {page, process, 6'b0} |
| entry_lo_o | output | 32 | Low entry word {frame, nocache, writable, valid, global, 8'b0} |
| index_o | output | 7 | Index register, bit 6 = probe found nothing |
| random_o | output | 6 | Random victim counter |

## Verification
Directed lookups cover each segment against both modes. This separates the address-error path from the two bypass windows, and it separates those windows from each other by the cacheable flag alone. Mapped lookups are set against entries built to differ in a single field: process number, global flag, valid flag, writable flag and no-cache flag. As a result, a wrong match rule or wrong fault priority shows up as a different result kind rather than just a different address. Probe is tried with a hit and a miss, and read and both write operations are followed by lookups that can only succeed if the right entry was moved. A random phase then mixes lookups, register writes, ignored writes, probes and reads against a behavioural model that is compared every cycle. The same per-cycle comparison covers the random counter across several wraps.

// File: rtl/seg_tlb_pkg.sv
package seg_tlb_pkg;
    parameter int VA_W   = 32;
    parameter int PAGE_W = 12;
    parameter int VPN_W  = VA_W - PAGE_W;
    parameter int PID_W  = 6;
    parameter int PFN_W  = 20;
    parameter int WIN_W  = VA_W - 3;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [PID_W-1:0] pid;
        logic [PFN_W-1:0] pfn;
        logic             nc;
        logic             dirty;
        logic             valid;
        logic             glob;
    } tlb_ent_t;

    typedef enum logic [2:0] {
        XL_HIT      = 3'd0,
        XL_ADDR_ERR = 3'd1,
        XL_UMISS    = 3'd2,
        XL_KMISS    = 3'd3,
        XL_MOD      = 3'd4
    } xl_kind_e;

    typedef enum logic [1:0] {
        SEG_USEG,
        SEG_KCACHED,
        SEG_KUNCACHED,
        SEG_KMAPPED
    } seg_e;

    typedef enum logic [1:0] {
        OP_PROBE  = 2'd0,
        OP_READ   = 2'd1,
        OP_WR_IDX = 2'd2,
        OP_WR_RND = 2'd3
    } tlb_op_e;

    typedef enum logic [1:0] {
        RS_HI   = 2'd0,
        RS_LO   = 2'd1,
        RS_IDX  = 2'd2,
        RS_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/seg_tlb_cam.sv
module seg_tlb_cam
    import seg_tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_ent_t         wr_ent,
    input  logic [PID_W-1:0] cur_pid,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    output logic             lk_nc,
    output logic             lk_dirty,
    output logic             lk_valid,
    input  logic [VPN_W-1:0] pb_vpn,
    output logic             pb_hit,
    output logic [IDX_W-1:0] pb_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output tlb_ent_t         rd_ent
);
    tlb_ent_t         mem [ENTRIES];
    logic [ENTRIES-1:0] lk_m;
    logic [ENTRIES-1:0] pb_m;
    logic [IDX_W-1:0]   lk_idx;
    tlb_ent_t           lk_ent;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_ent;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign lk_m[g] = (mem[g].vpn == lk_vpn) && (mem[g].glob || mem[g].pid == cur_pid);
        assign pb_m[g] = (mem[g].vpn == pb_vpn) && (mem[g].glob || mem[g].pid == cur_pid);
    end

    // lowest matching index wins
    always_comb begin
        lk_idx = '0;
        pb_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (lk_m[i]) lk_idx = IDX_W'(i);
            if (pb_m[i]) pb_idx = IDX_W'(i);
        end
    end

    assign lk_hit   = |lk_m;
    assign pb_hit   = |pb_m;
    assign lk_ent   = mem[lk_idx];
    assign lk_pfn   = lk_ent.pfn;
    assign lk_nc    = lk_ent.nc;
    assign lk_dirty = lk_ent.dirty;
    assign lk_valid = lk_ent.valid;
    assign rd_ent   = mem[rd_idx];
endmodule

// File: rtl/seg_tlb_random.sv
module seg_tlb_random #(
    parameter int ENTRIES = 64,
    parameter int WIRED   = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] rnd
);
    localparam logic [IDX_W-1:0] TOP   = IDX_W'(ENTRIES - 1);
    localparam logic [IDX_W-1:0] FLOOR = IDX_W'(WIRED);

    always_ff @(posedge clk) begin
        if (!rst_n)            rnd <= TOP;
        else if (rnd == FLOOR) rnd <= TOP;
        else                   rnd <= rnd - 1'b1;
    end
endmodule

// File: rtl/seg_tlb_classify.sv
module seg_tlb_classify
    import seg_tlb_pkg::*;
(
    input  logic [VA_W-1:0]  va,
    input  logic             user_mode,
    input  logic             is_write,
    input  logic             lk_hit,
    input  logic [PFN_W-1:0] lk_pfn,
    input  logic             lk_nc,
    input  logic             lk_dirty,
    input  logic             lk_valid,
    output xl_kind_e         kind,
    output logic [VA_W-1:0]  pa,
    output logic             cacheable
);
    seg_e seg;

    always_comb begin
        if (!va[VA_W-1])       seg = SEG_USEG;
        else if (va[VA_W-2])   seg = SEG_KMAPPED;
        else if (va[VA_W-3])   seg = SEG_KUNCACHED;
        else                   seg = SEG_KCACHED;
    end

    always_comb begin
        kind      = XL_HIT;
        pa        = '0;
        cacheable = 1'b0;
        if (user_mode && va[VA_W-1]) begin
            kind = XL_ADDR_ERR;
        end else begin
            unique case (seg)
                SEG_KCACHED: begin
                    pa        = {3'b000, va[WIN_W-1:0]};
                    cacheable = 1'b1;
                end
                SEG_KUNCACHED: begin
                    pa        = {3'b000, va[WIN_W-1:0]};
                end
                SEG_USEG, SEG_KMAPPED: begin
                    if (!lk_hit)
                        kind = va[VA_W-1] ? XL_KMISS : XL_UMISS;
                    else if (!lk_valid)
                        kind = XL_KMISS;
                    else if (is_write && !lk_dirty)
                        kind = XL_MOD;
                    else begin
                        pa        = {lk_pfn, va[PAGE_W-1:0]};
                        cacheable = !lk_nc;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/seg_tlb_xlate.sv
module seg_tlb_xlate
    import seg_tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int WIRED   = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      va_i,
    input  logic             user_mode_i,
    input  logic             is_write_i,
    output logic [31:0]      pa_o,
    output logic [2:0]       kind_o,
    output logic             cacheable_o,
    input  logic             reg_wr_en_i,
    input  logic [1:0]       reg_sel_i,
    input  logic [31:0]      reg_wdata_i,
    input  logic             op_en_i,
    input  logic [1:0]       op_i,
    output logic [31:0]      entry_hi_o,
    output logic [31:0]      entry_lo_o,
    output logic [IDX_W:0]   index_o,
    output logic [IDX_W-1:0] random_o
);
    logic [VPN_W-1:0] hi_vpn_q;
    logic [PID_W-1:0] hi_pid_q;
    logic [PFN_W-1:0] lo_pfn_q;
    logic             lo_nc_q, lo_d_q, lo_v_q, lo_g_q;
    logic [IDX_W:0]   idx_q;
    logic [IDX_W-1:0] rnd;

    tlb_op_e          op;
    reg_sel_e         sel;
    tlb_ent_t         wr_ent, rd_ent;
    logic             cam_wr;
    logic [IDX_W-1:0] cam_wr_idx;
    logic             lk_hit, lk_nc, lk_dirty, lk_valid, pb_hit;
    logic [PFN_W-1:0] lk_pfn;
    logic [IDX_W-1:0] pb_idx;
    xl_kind_e         kind;

    assign op  = tlb_op_e'(op_i);
    assign sel = reg_sel_e'(reg_sel_i);

    assign wr_ent     = '{vpn: hi_vpn_q, pid: hi_pid_q, pfn: lo_pfn_q,
                          nc: lo_nc_q, dirty: lo_d_q, valid: lo_v_q, glob: lo_g_q};
    assign cam_wr     = op_en_i && (op == OP_WR_IDX || op == OP_WR_RND);
    assign cam_wr_idx = (op == OP_WR_RND) ? rnd : idx_q[IDX_W-1:0];

    seg_tlb_cam #(.ENTRIES(ENTRIES)) i_cam (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cam_wr), .wr_idx(cam_wr_idx), .wr_ent(wr_ent),
        .cur_pid(hi_pid_q),
        .lk_vpn(va_i[VA_W-1:PAGE_W]), .lk_hit(lk_hit), .lk_pfn(lk_pfn),
        .lk_nc(lk_nc), .lk_dirty(lk_dirty), .lk_valid(lk_valid),
        .pb_vpn(hi_vpn_q), .pb_hit(pb_hit), .pb_idx(pb_idx),
        .rd_idx(idx_q[IDX_W-1:0]), .rd_ent(rd_ent)
    );

    seg_tlb_random #(.ENTRIES(ENTRIES), .WIRED(WIRED)) i_rnd (
        .clk(clk), .rst_n(rst_n), .rnd(rnd)
    );

    seg_tlb_classify i_cls (
        .va(va_i), .user_mode(user_mode_i), .is_write(is_write_i),
        .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_nc(lk_nc),
        .lk_dirty(lk_dirty), .lk_valid(lk_valid),
        .kind(kind), .pa(pa_o), .cacheable(cacheable_o)
    );

    // maintenance register state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_vpn_q <= '0;
            hi_pid_q <= '0;
            lo_pfn_q <= '0;
            {lo_nc_q, lo_d_q, lo_v_q, lo_g_q} <= '0;
            idx_q    <= '0;
        end else if (op_en_i) begin
            unique case (op)
                OP_PROBE:  idx_q <= pb_hit ? {1'b0, pb_idx} : {1'b1, {IDX_W{1'b0}}};
                OP_READ: begin
                    hi_vpn_q <= rd_ent.vpn;
                    hi_pid_q <= rd_ent.pid;
                    lo_pfn_q <= rd_ent.pfn;
                    {lo_nc_q, lo_d_q, lo_v_q, lo_g_q} <=
                        {rd_ent.nc, rd_ent.dirty, rd_ent.valid, rd_ent.glob};
                end
                OP_WR_IDX, OP_WR_RND: ;
            endcase
        end else if (reg_wr_en_i) begin
            unique case (sel)
                RS_HI: begin
                    hi_vpn_q <= reg_wdata_i[31:32-VPN_W];
                    hi_pid_q <= reg_wdata_i[31-VPN_W:32-VPN_W-PID_W];
                end
                RS_LO: begin
                    lo_pfn_q <= reg_wdata_i[31:32-PFN_W];
                    {lo_nc_q, lo_d_q, lo_v_q, lo_g_q} <= reg_wdata_i[31-PFN_W:28-PFN_W];
                end
                RS_IDX:  idx_q <= {reg_wdata_i[31], reg_wdata_i[IDX_W-1:0]};
                RS_NONE: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        kind_o     = kind;
        entry_hi_o = {hi_vpn_q, hi_pid_q, {(32-VPN_W-PID_W){1'b0}}};
        entry_lo_o = {lo_pfn_q, lo_nc_q, lo_d_q, lo_v_q, lo_g_q, {(28-PFN_W){1'b0}}};
        index_o    = idx_q;
        random_o   = rnd;
    end
endmodule

// File: rtl/seg_tlb_xlate_chk.sv
module seg_tlb_xlate_chk #(
    parameter int ENTRIES = 64,
    parameter int WIRED   = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      va_i,
    input logic             user_mode_i,
    input logic [31:0]      pa_o,
    input logic [2:0]       kind_o,
    input logic             cacheable_o,
    input logic             op_en_i,
    input logic [1:0]       op_i,
    input logic [IDX_W:0]   index_o,
    input logic [IDX_W-1:0] random_o
);
    a_r12_random_floor: assert property (@(posedge clk) disable iff (!rst_n)
        random_o >= IDX_W'(WIRED));

    a_r12_random_step: assert property (@(posedge clk) disable iff (!rst_n)
        (random_o != IDX_W'(WIRED)) |=> (random_o == $past(random_o) - 1'b1));

    a_r12_random_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (random_o == IDX_W'(WIRED)) |=> (random_o == IDX_W'(ENTRIES - 1)));

    a_r2_addr_err: assert property (@(posedge clk) disable iff (!rst_n)
        (user_mode_i && va_i[31]) |-> (kind_o == 3'd1));

    a_r3_kseg_cached: assert property (@(posedge clk) disable iff (!rst_n)
        (!user_mode_i && va_i[31:29] == 3'b100) |->
        (kind_o == 3'd0 && cacheable_o && pa_o == {3'b000, va_i[28:0]}));

    a_r4_kseg_uncached: assert property (@(posedge clk) disable iff (!rst_n)
        (!user_mode_i && va_i[31:29] == 3'b101) |->
        (kind_o == 3'd0 && !cacheable_o && pa_o == {3'b000, va_i[28:0]}));

    a_r6_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_o != 3'd0) |-> (pa_o == 32'd0 && !cacheable_o));

    a_r9_probe_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en_i && op_i == 2'd0) |=> (!index_o[IDX_W] || index_o[IDX_W-1:0] == '0));
endmodule

bind seg_tlb_xlate seg_tlb_xlate_chk #(.ENTRIES(ENTRIES), .WIRED(WIRED)) i_chk (
    .clk(clk), .rst_n(rst_n), .va_i(va_i), .user_mode_i(user_mode_i),
    .pa_o(pa_o), .kind_o(kind_o), .cacheable_o(cacheable_o),
    .op_en_i(op_en_i), .op_i(op_i), .index_o(index_o), .random_o(random_o)
);

// File: tb/test_seg_tlb_xlate.sv
`timescale 1ns/1ps
module test_seg_tlb_xlate;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] va = '0;
    logic        um = 1'b0, wr = 1'b0;
    logic [31:0] pa;
    logic [2:0]  kind;
    logic        cach;
    logic        rwe = 1'b0;
    logic [1:0]  rsel = '0;
    logic [31:0] rdat = '0;
    logic        oen = 1'b0;
    logic [1:0]  op = '0;
    logic [31:0] ehi, elo;
    logic [6:0]  idx;
    logic [5:0]  rnd;

    int checks = 0;
    int fails  = 0;
    string note = "";

    always #(CLK_NS/2) clk = ~clk;

    seg_tlb_xlate i_seg_tlb_xlate (
        .clk(clk), .rst_n(rst_n), .va_i(va), .user_mode_i(um), .is_write_i(wr),
        .pa_o(pa), .kind_o(kind), .cacheable_o(cach),
        .reg_wr_en_i(rwe), .reg_sel_i(rsel), .reg_wdata_i(rdat),
        .op_en_i(oen), .op_i(op),
        .entry_hi_o(ehi), .entry_lo_o(elo), .index_o(idx), .random_o(rnd)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_hi [64];
    logic [31:0] m_lo [64];
    logic [31:0] m_ehi, m_elo;
    logic [6:0]  m_idx;
    int          m_rnd;

    function automatic int find(input logic [19:0] vpn);
        for (int i = 0; i < 64; i++)
            if (m_hi[i][31:12] == vpn && (m_lo[i][8] || m_hi[i][11:6] == m_ehi[11:6]))
                return i;
        return -1;
    endfunction

    task automatic expect_lookup(output logic [2:0] k, output logic [31:0] p,
                                 output logic c, output string tag);
        int f;
        k = 3'd0; p = '0; c = 1'b0;
        if (um && va[31]) begin k = 3'd1; tag = "R2"; end
        else if (va[31:29] == 3'b100) begin p = {3'b000, va[28:0]}; c = 1'b1; tag = "R3"; end
        else if (va[31:29] == 3'b101) begin p = {3'b000, va[28:0]}; tag = "R4"; end
        else begin
            f = find(va[31:12]);
            if (f < 0) begin k = va[31] ? 3'd3 : 3'd2; tag = "R6"; end
            else if (!m_lo[f][9]) begin k = 3'd3; tag = "R7"; end
            else if (wr && !m_lo[f][10]) begin k = 3'd4; tag = "R8"; end
            else begin p = {m_lo[f][31:12], va[11:0]}; c = !m_lo[f][11]; tag = "R5"; end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) begin m_hi[i] = '0; m_lo[i] = '0; end
            m_ehi = '0; m_elo = '0; m_idx = '0; m_rnd = 63;
        end else begin
            if (oen) begin
                case (op)
                    2'd0: begin
                        int f;
                        f = find(m_ehi[31:12]);
                        m_idx = (f < 0) ? 7'h40 : {1'b0, 6'(f)};
                    end
                    2'd1: begin m_ehi = m_hi[m_idx[5:0]]; m_elo = m_lo[m_idx[5:0]]; end
                    2'd2: begin m_hi[m_idx[5:0]] = m_ehi; m_lo[m_idx[5:0]] = m_elo; end
                    default: begin m_hi[m_rnd] = m_ehi; m_lo[m_rnd] = m_elo; end
                endcase
            end else if (rwe) begin
                case (rsel)
                    2'd0: m_ehi = rdat & 32'hFFFF_FFC0;
                    2'd1: m_elo = rdat & 32'hFFFF_FF00;
                    2'd2: m_idx = {rdat[31], rdat[5:0]};
                    default: ;
                endcase
            end
            m_rnd = (m_rnd == 8) ? 63 : m_rnd - 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s %s act=%h exp=%h t=%0t", tag, note, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        logic [2:0] ek; logic [31:0] ep; logic ec; string tag;
        #4;
        if (rst_n) begin
            expect_lookup(ek, ep, ec, tag);
            chk(kind == ek, tag, "kind", 32'(kind), 32'(ek));
            chk(pa == ep, tag, "pa", pa, ep);
            chk(cach == ec, tag, "cacheable", 32'(cach), 32'(ec));
            chk(ehi == m_ehi, "R10 R13", "entry_hi", ehi, m_ehi);
            chk(elo == m_elo, "R10 R13", "entry_lo", elo, m_elo);
            chk(idx == m_idx, "R9 R13", "index", 32'(idx), 32'(m_idx));
            chk(rnd == 6'(m_rnd), "R12", "random", 32'(rnd), 32'(m_rnd));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic do_reg(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk); rwe = 1'b1; rsel = s; rdat = d; oen = 1'b0;
    endtask

    task automatic do_op(input logic [1:0] o);
        @(negedge clk); rwe = 1'b0; oen = 1'b1; op = o;
    endtask

    task automatic look(input logic [31:0] a, input logic u, input logic w);
        @(negedge clk); rwe = 1'b0; oen = 1'b0; va = a; um = u; wr = w;
    endtask

    task automatic load_entry(input int i, input logic [31:0] h, input logic [31:0] l);
        do_reg(2'd0, h); do_reg(2'd1, l); do_reg(2'd2, 32'(i)); do_op(2'd2);
    endtask

    logic [19:0] pool [8] = '{20'h00400, 20'h00401, 20'h00402, 20'h00403,
                              20'hC0000, 20'h00404, 20'h80123, 20'hA0456};

    initial begin
        #(CLK_NS * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        va = 32'h1234_5000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #4;
        // R1: state right after reset
        note = "reset";
        chk(ehi == 0, "R1", "entry_hi", ehi, 0);
        chk(elo == 0, "R1", "entry_lo", elo, 0);
        chk(idx == 0, "R1", "index", 32'(idx), 0);
        chk(rnd == 6'd63, "R1", "random", 32'(rnd), 63);
        chk(kind == 3'd2, "R1", "empty tlb kind", 32'(kind), 2);

        note = "fill";
        load_entry(1, 32'h0040_0140, 32'h1234_5600);
        load_entry(2, 32'h0040_1140, 32'h2345_6A00);
        load_entry(3, 32'hC000_0240, 32'h3456_7700);
        load_entry(4, 32'h0040_21C0, 32'h4567_8600);
        load_entry(5, 32'h0040_3140, 32'h5678_9400);
        note = "R11 random write";
        do_reg(2'd0, 32'h0040_4140); do_reg(2'd1, 32'h6789_A600); do_op(2'd3);
        do_reg(2'd0, 32'h0000_0140);

        note = "directed";
        look(32'h8000_0000, 1, 0);   // R2
        look(32'hC000_0010, 1, 1);   // R2
        look(32'h8012_3456, 0, 0);   // R3
        look(32'hA012_3456, 0, 1);   // R4
        look(32'h0040_0ABC, 1, 0);   // R5 hit
        look(32'h0040_0ABC, 1, 1);   // R5 writable
        look(32'h0040_1123, 1, 0);   // R5 no-cache
        look(32'h0040_1123, 1, 1);   // R8 modify
        look(32'hC000_0777, 0, 1);   // R5 global
        look(32'h0040_2000, 1, 0);   // R6 other pid
        look(32'h0050_0000, 0, 0);   // R6 user miss
        look(32'hC010_0000, 0, 0);   // R6 kernel miss
        look(32'h0040_3000, 1, 0);   // R7 invalid
        note = "R11";
        look(32'h0040_4FFF, 1, 1);   // entry from random write
        note = "R9 probe";
        do_reg(2'd0, 32'h0040_1140); do_op(2'd0);
        do_reg(2'd0, 32'h0099_9140); do_op(2'd0);
        note = "R10 read";
        do_reg(2'd2, 32'd3); do_op(2'd1);
        look(32'hC000_0123, 0, 0);
        note = "R13 ignored";
        do_reg(2'd3, 32'hFFFF_FFFF);
        @(negedge clk); rwe = 1'b1; rsel = 2'd0; rdat = 32'hDEAD_BEEF; oen = 1'b1; op = 2'd0;
        look(32'h0040_0000, 1, 0);
        note = "R12 sweep";
        repeat (130) look(32'h0040_0123, 1, 0);

        note = "mixed";
        for (int n = 0; n < 600; n++) begin
            int a;
            logic [31:0] v;
            a = $urandom % 11;
            v = ($urandom % 4 == 0) ? $urandom : {pool[$urandom % 8], 12'($urandom)};
            @(negedge clk);
            va = v; um = 1'($urandom); wr = 1'($urandom);
            rwe = 1'b0; oen = 1'b0;
            case (a)
                5: begin rwe = 1'b1; rsel = 2'd0;
                         rdat = {pool[$urandom % 8], (($urandom % 2) ? 6'd5 : 6'd7), 6'($urandom)}; end
                6: begin rwe = 1'b1; rsel = 2'd2; rdat = $urandom; end
                7: begin oen = 1'b1; op = 2'd0; end
                8: begin oen = 1'b1; op = 2'd1; end
                9: begin rwe = 1'b1; rsel = 2'd3; rdat = $urandom; end
                10: begin rwe = 1'b1; rsel = 2'($urandom % 2); rdat = $urandom;
                          oen = 1'b1; op = 2'd0; end
                default: ;
            endcase
        end
        look(32'h0, 0, 0);
        @(negedge clk);
        #6;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule